// File: doc/BRIEF.md
# Time-Slot Scheduled Crossbar Router

This router forwards flits across a crossbar whose connections are picked only by the current time slot. A free-running slot counter steps through a fixed number of slots and wraps. A per-slot, per-output table entry names the input that feeds that output in that slot, or marks the output idle. The router reads no field of the flit to route it. The schedule is conflict-free by construction, because each output names at most one source, so there is no arbitration. One input may still feed several outputs in the same slot.

Each input has exactly one flit register. A flit present on an input during slot i is captured in the last clock cycle of that slot. It is presented during the whole of slot (i+1) mod N_SLOTS on every output that the table connects to that input for that departure slot. All routers of a network share the slot count and slot length and step in lock-step.

The table is loaded through a write port. Each write lands in a shadow copy. The whole shadow copy is promoted into the routing copy at every slot boundary, so routing never changes part-way through a slot.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset the slot index is 0, every table entry is idle and every flit register is empty, so all outputs show valid low and data zero until the schedule is loaded and flits arrive.
- R2: A slot lasts SLOT_CYCLES clock cycles. The slot index advances by one at the end of each slot and wraps from N_SLOTS-1 to 0.
- R3: A flit whose input valid is high in the last cycle of slot i leaves during slot (i+1) mod N_SLOTS on each output whose table entry for that departure slot is enabled and selects that input. Its data is unchanged, and the data bits never affect routing.
- R4: Output valid and data stay constant over all cycles of one slot.
- R5: An input whose valid is low in the last cycle of slot i produces no valid output in slot i+1, even on outputs scheduled to take it. A flit is held for one slot only.
- R6: An output whose entry for the current slot is disabled, or whose entry selects an input number at or above N_IN, drives valid low. Any output with valid low drives data zero.
- R7: A table write (cfg_we_i high) stores {cfg_en_i, cfg_sel_i} as the entry for slot cfg_slot_i and output cfg_port_i. A write made in any cycle of slot k governs routing from the start of slot k+1 and never alters routing within slot k.
- R8: A write whose cfg_slot_i is N_SLOTS or above, or whose cfg_port_i is N_OUT or above, changes no entry.
- R9: Several outputs may select the same input in one slot, and each of them carries that input's flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_IN | Per-input flit valid |
| in_data_i | input | N_IN*DATA_W | Per-input flit data, input j at bits j*DATA_W upward |
| out_valid_o | output | N_OUT | Per-output flit valid |
| out_data_o | output | N_OUT*DATA_W | Per-output flit data, output k at bits k*DATA_W upward |
| cfg_we_i | input | 1 | Table write enable |
| cfg_slot_i | input | SLOT_W | Slot address of the entry written |
| cfg_port_i | input | OPORT_W | Output port of the entry written |
| cfg_en_i | input | 1 | Entry enable bit written |
| cfg_sel_i | input | IPORT_W | Entry input select written |

## Verification
The bench builds the router with 4 inputs, 4 outputs, 16-bit data, 6 slots and 2 cycles per slot. With a slot count that is not a power of two, the 3-bit slot address can name slots 6 and 7, which do not exist, so the ignored-write rule and the wrap from 5 to 0 can both be reached. With two cycles per slot, the bench can make a table write in the first cycle of a slot and look at the second cycle of the same slot. That shows routing holds steady within a slot and that input capture happens only at the slot's end.

// File: rtl/tdm_rtr_pkg.sv
package tdm_rtr_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned N_SLOTS     = 8,
  parameter int unsigned SLOT_CYCLES = 1,
  parameter int unsigned SLOT_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_end_o
);
  localparam int unsigned CYC_W = tdm_rtr_pkg::idx_w(SLOT_CYCLES);

  logic [SLOT_W-1:0] slot_q;
  logic              slot_last;

  generate
    if (SLOT_CYCLES == 1) begin : g_single
      assign slot_end_o = 1'b1;
    end else begin : g_multi
      logic [CYC_W-1:0] cyc_q;
      assign slot_end_o = (cyc_q == CYC_W'(SLOT_CYCLES - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cyc_q <= '0;
        else if (slot_end_o) cyc_q <= '0;
        else                 cyc_q <= cyc_q + 1'b1;
      end
    end
  endgenerate

  assign slot_last = (slot_q == SLOT_W'(N_SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         slot_q <= '0;
    else if (slot_end_o) slot_q <= slot_last ? '0 : slot_q + 1'b1;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_OUT   = 4,
  parameter int unsigned SLOT_W  = 3,
  parameter int unsigned OPORT_W = 2,
  parameter int unsigned IPORT_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     slot_end_i,
  input  logic [SLOT_W-1:0]        rd_slot_i,
  input  logic                     cfg_we_i,
  input  logic [SLOT_W-1:0]        cfg_slot_i,
  input  logic [OPORT_W-1:0]       cfg_port_i,
  input  logic                     cfg_en_i,
  input  logic [IPORT_W-1:0]       cfg_sel_i,
  output logic [N_OUT-1:0]         ent_en_o,
  output logic [N_OUT*IPORT_W-1:0] ent_sel_o
);
  localparam int unsigned ENT_W  = IPORT_W + 1;
  localparam int unsigned N_ENT  = N_SLOTS * N_OUT;

  logic [N_ENT*ENT_W-1:0] act_flat;

  // shadow takes writes at once; routing copy follows at slot boundaries
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      localparam int unsigned K = s * N_OUT + o;
      logic             hit;
      logic [ENT_W-1:0] shd_q, shd_d, act_q;

      assign hit   = cfg_we_i && (cfg_slot_i == SLOT_W'(s)) && (cfg_port_i == OPORT_W'(o));
      assign shd_d = hit ? {cfg_en_i, cfg_sel_i} : shd_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shd_q <= '0;
          act_q <= '0;
        end else begin
          shd_q <= shd_d;
          if (slot_end_i) act_q <= shd_d;
        end
      end

      assign act_flat[K*ENT_W +: ENT_W] = act_q;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_rd
    logic [ENT_W-1:0] ent;
    always_comb begin
      ent = '0;
      for (int s = 0; s < N_SLOTS; s++)
        if (rd_slot_i == SLOT_W'(s)) ent = act_flat[(s*N_OUT+o)*ENT_W +: ENT_W];
    end
    assign ent_en_o[o]                    = ent[IPORT_W];
    assign ent_sel_o[o*IPORT_W +: IPORT_W] = ent[IPORT_W-1:0];
  end
endmodule

// File: rtl/tdm_flit_stage.sv
module tdm_flit_stage #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   capture_i,
  input  logic [N_IN-1:0]        in_valid_i,
  input  logic [N_IN*DATA_W-1:0] in_data_i,
  output logic [N_IN-1:0]        flit_valid_o,
  output logic [N_IN*DATA_W-1:0] flit_data_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flit_valid_o[i]                 <= 1'b0;
        flit_data_o[i*DATA_W +: DATA_W] <= '0;
      end else if (capture_i) begin
        flit_valid_o[i]                 <= in_valid_i[i];
        flit_data_o[i*DATA_W +: DATA_W] <= in_data_i[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/tdm_xbar.sv
module tdm_xbar #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IPORT_W = 2
) (
  input  logic [N_OUT-1:0]         ent_en_i,
  input  logic [N_OUT*IPORT_W-1:0] ent_sel_i,
  input  logic [N_IN-1:0]          flit_valid_i,
  input  logic [N_IN*DATA_W-1:0]   flit_data_i,
  output logic [N_OUT-1:0]         out_valid_o,
  output logic [N_OUT*DATA_W-1:0]  out_data_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [IPORT_W-1:0] sel;
    assign sel = ent_sel_i[o*IPORT_W +: IPORT_W];
    always_comb begin
      out_valid_o[o]                 = 1'b0;
      out_data_o[o*DATA_W +: DATA_W] = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (ent_en_i[o] && sel == IPORT_W'(i) && flit_valid_i[i]) begin
          out_valid_o[o]                 = 1'b1;
          out_data_o[o*DATA_W +: DATA_W] = flit_data_i[i*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
  parameter  int unsigned N_IN        = 4,
  parameter  int unsigned N_OUT       = 4,
  parameter  int unsigned DATA_W      = 32,
  parameter  int unsigned N_SLOTS     = 8,
  parameter  int unsigned SLOT_CYCLES = 1,
  localparam int unsigned SLOT_W      = tdm_rtr_pkg::idx_w(N_SLOTS),
  localparam int unsigned OPORT_W     = tdm_rtr_pkg::idx_w(N_OUT),
  localparam int unsigned IPORT_W     = tdm_rtr_pkg::idx_w(N_IN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IN-1:0]         in_valid_i,
  input  logic [N_IN*DATA_W-1:0]  in_data_i,
  output logic [N_OUT-1:0]        out_valid_o,
  output logic [N_OUT*DATA_W-1:0] out_data_o,
  input  logic                    cfg_we_i,
  input  logic [SLOT_W-1:0]       cfg_slot_i,
  input  logic [OPORT_W-1:0]      cfg_port_i,
  input  logic                    cfg_en_i,
  input  logic [IPORT_W-1:0]      cfg_sel_i
);
  logic [SLOT_W-1:0]        slot_q;
  logic                     slot_end;
  logic [N_OUT-1:0]         ent_en;
  logic [N_OUT*IPORT_W-1:0] ent_sel;
  logic [N_IN-1:0]          flit_valid;
  logic [N_IN*DATA_W-1:0]   flit_data;

  tdm_slot_timer #(
    .N_SLOTS(N_SLOTS), .SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(SLOT_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_o(slot_q), .slot_end_o(slot_end)
  );

  tdm_slot_table #(
    .N_SLOTS(N_SLOTS), .N_OUT(N_OUT), .SLOT_W(SLOT_W),
    .OPORT_W(OPORT_W), .IPORT_W(IPORT_W)
  ) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_end_i(slot_end), .rd_slot_i(slot_q),
    .cfg_we_i(cfg_we_i), .cfg_slot_i(cfg_slot_i), .cfg_port_i(cfg_port_i),
    .cfg_en_i(cfg_en_i), .cfg_sel_i(cfg_sel_i),
    .ent_en_o(ent_en), .ent_sel_o(ent_sel)
  );

  tdm_flit_stage #(
    .N_IN(N_IN), .DATA_W(DATA_W)
  ) u_flits (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(slot_end),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .flit_valid_o(flit_valid), .flit_data_o(flit_data)
  );

  tdm_xbar #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .IPORT_W(IPORT_W)
  ) u_xbar (
    .ent_en_i(ent_en), .ent_sel_i(ent_sel),
    .flit_valid_i(flit_valid), .flit_data_i(flit_data),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );
endmodule

// File: rtl/tdm_router_checker.sv
module tdm_router_checker #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned SLOT_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [SLOT_W-1:0]       slot_i,
  input logic                    slot_end_i,
  input logic [N_IN-1:0]         in_valid_i,
  input logic [N_OUT-1:0]        out_valid_i,
  input logic [N_OUT*DATA_W-1:0] out_data_i
);
  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i < SLOT_W'(N_SLOTS - 1) || slot_i == SLOT_W'(N_SLOTS - 1)); // R2

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && slot_i == SLOT_W'(N_SLOTS - 1)) |=> slot_i == '0); // R2

  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(slot_i)); // R2

  AST_OUT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> ($stable(out_valid_i) && $stable(out_data_i))); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && in_valid_i == '0) |=> out_valid_i == '0); // R5

  for (genvar o = 0; o < N_OUT; o++) begin : g_idle
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_i[o] |-> out_data_i[o*DATA_W +: DATA_W] == '0); // R6
  end
endmodule

bind tdm_slot_router tdm_router_checker #(
  .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_q), .slot_end_i(slot_end),
  .in_valid_i(in_valid_i), .out_valid_i(out_valid_o), .out_data_i(out_data_o)
);

// File: tb/tdm_slot_router_bench.sv
module tdm_slot_router_bench;
  localparam int N_IN = 4, N_OUT = 4, DATA_W = 16, N_SLOTS = 6, SLOT_CYCLES = 2;
  localparam int SLOT_W = 3, OPORT_W = 2, IPORT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_IN-1:0]         in_valid = '0;
  logic [N_IN*DATA_W-1:0]  in_data = '0;
  logic [N_OUT-1:0]        out_valid;
  logic [N_OUT*DATA_W-1:0] out_data;
  logic                    cfg_we = 1'b0, cfg_en = 1'b0;
  logic [SLOT_W-1:0]       cfg_slot = '0;
  logic [OPORT_W-1:0]      cfg_port = '0;
  logic [IPORT_W-1:0]      cfg_sel = '0;

  tdm_slot_router #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .SLOT_CYCLES(SLOT_CYCLES)
  ) u_tdm_slot_router (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_port_i(cfg_port),
    .cfg_en_i(cfg_en), .cfg_sel_i(cfg_sel)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int b_cyc = 0, b_slot = 0;
  bit m_en [N_SLOTS][N_OUT];
  int m_sel[N_SLOTS][N_OUT];
  bit s_en [N_OUT];
  int s_sel[N_OUT];
  bit p_val[N_IN];
  logic [DATA_W-1:0] p_dat[N_IN];
  bit drv_val[N_IN];
  logic [DATA_W-1:0] drv_dat[N_IN];

  // independent slot-time model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cyc  <= 0;
      b_slot <= 0;
    end else if (b_cyc == SLOT_CYCLES - 1) begin
      b_cyc  <= 0;
      b_slot <= (b_slot + 1) % N_SLOTS;
    end else begin
      b_cyc <= b_cyc + 1;
    end
  end

  task automatic check_out(input string tag);
    for (int o = 0; o < N_OUT; o++) begin
      bit ev;
      logic [DATA_W-1:0] ed;
      ev = s_en[o] && s_sel[o] < N_IN && p_val[s_sel[o]];
      ed = ev ? p_dat[s_sel[o]] : '0;
      n_chk++;
      if (out_valid[o] !== ev || out_data[o*DATA_W +: DATA_W] !== ed) begin
        n_bad++;
        $display("FAIL %s slot %0d out %0d: actual v=%0b d=%h expected v=%0b d=%h",
                 tag, b_slot, o, out_valid[o], out_data[o*DATA_W +: DATA_W], ev, ed);
      end
    end
  endtask

  task automatic wait_slot_start();
    @(negedge clk);
    while (b_cyc != 0) @(negedge clk);
  endtask

  // checks the current slot while driving flits for the next one
  task automatic run_slot(input string tag, input bit do_wr = 0, input int wslot = 0,
                          input int wport = 0, input bit wen = 0, input int wsel = 0);
    wait_slot_start();
    cfg_we = 1'b0;
    for (int o = 0; o < N_OUT; o++) begin
      s_en[o]  = m_en[b_slot][o];
      s_sel[o] = m_sel[b_slot][o];
    end
    for (int i = 0; i < N_IN; i++) begin
      in_valid[i] = drv_val[i];
      in_data[i*DATA_W +: DATA_W] = drv_dat[i];
    end
    for (int c = 0; c < SLOT_CYCLES; c++) begin
      if (c > 0) begin
        @(negedge clk);
        cfg_we = 1'b0;
      end
      check_out(tag);
      if (c == 0 && do_wr) begin
        cfg_we = 1'b1; cfg_slot = SLOT_W'(wslot); cfg_port = OPORT_W'(wport);
        cfg_en = wen;  cfg_sel = IPORT_W'(wsel);
        if (wslot < N_SLOTS && wport < N_OUT) begin
          m_en[wslot][wport]  = wen;
          m_sel[wslot][wport] = wsel;
        end
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      p_val[i] = drv_val[i];
      p_dat[i] = drv_dat[i];
    end
  endtask

  task automatic set_flits(input int vmode);
    for (int i = 0; i < N_IN; i++) begin
      drv_val[i] = (vmode == 1) ? 1'b1 : (vmode == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
      drv_dat[i] = DATA_W'($urandom);
    end
  endtask

  task automatic cfg_write(input int s, input int o, input bit en, input int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = SLOT_W'(s); cfg_port = OPORT_W'(o);
    cfg_en = en;   cfg_sel = IPORT_W'(sel);
    if (s < N_SLOTS && o < N_OUT) begin
      m_en[s][o]  = en;
      m_sel[s][o] = sel;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_out("R1 reset");
    set_flits(1);
    for (int k = 0; k < N_SLOTS; k++) run_slot("R1 idle table");
  endtask

  task automatic t_load_random();
    in_valid = '0;
    for (int s = 0; s < N_SLOTS; s++)
      for (int o = 0; o < N_OUT; o++)
        cfg_write(s, o, ($urandom_range(0, 3) != 0), $urandom_range(0, N_IN - 1));
    // forced multicast and a fully idle slot
    cfg_write(2, 0, 1, 3);
    cfg_write(2, 1, 1, 3);
    cfg_write(2, 3, 1, 3);
    for (int o = 0; o < N_OUT; o++) cfg_write(4, o, 0, o);
    for (int i = 0; i < N_IN; i++) p_val[i] = 0;
    set_flits(0);
  endtask

  task automatic t_stream();
    for (int k = 0; k < 2 * N_SLOTS + 1; k++) begin
      set_flits(1);
      run_slot("R3/R9 stream");
    end
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 2 * N_SLOTS; k++) begin
      set_flits(2);
      run_slot("R5 gaps");
    end
    set_flits(0);
    run_slot("R5 no input");
    run_slot("R5 no input");
  endtask

  task automatic t_idle_entry();
    set_flits(1);
    for (int k = 0; k < N_SLOTS; k++) run_slot("R6 idle entry");
  endtask

  task automatic t_midslot_write();
    int tgt;
    set_flits(1);
    run_slot("R7 pre");
    tgt = (b_slot + 1) % N_SLOTS;
    // rewrite the entry of the slot being entered, in its first cycle
    wait_slot_start();
    while (b_slot != tgt) wait_slot_start();
    for (int o = 0; o < N_OUT; o++) begin
      s_en[o]  = m_en[b_slot][o];
      s_sel[o] = m_sel[b_slot][o];
    end
    for (int i = 0; i < N_IN; i++) begin
      in_valid[i] = drv_val[i];
      in_data[i*DATA_W +: DATA_W] = drv_dat[i];
    end
    check_out("R7 before write");
    cfg_we = 1'b1; cfg_slot = SLOT_W'(tgt); cfg_port = '0;
    cfg_en = !m_en[tgt][0]; cfg_sel = IPORT_W'((m_sel[tgt][0] + 1) % N_IN);
    m_en[tgt][0]  = !m_en[tgt][0];
    m_sel[tgt][0] = (m_sel[tgt][0] + 1) % N_IN;
    for (int c = 1; c < SLOT_CYCLES; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      check_out("R7 same slot unchanged");
    end
    for (int i = 0; i < N_IN; i++) begin
      p_val[i] = drv_val[i];
      p_dat[i] = drv_dat[i];
    end
    for (int k = 0; k < N_SLOTS + 1; k++) begin
      set_flits(1);
      run_slot("R7 after write");
    end
  endtask

  task automatic t_oob_write();
    set_flits(1);
    run_slot("R8 oob", 1, 6, 0, 1, 1);
    set_flits(1);
    run_slot("R8 oob", 1, 7, 2, 0, 3);
    for (int k = 0; k < N_SLOTS + 1; k++) begin
      set_flits(1);
      run_slot("R8 table intact");
    end
  endtask

  bit done = 0;

  initial begin
    for (int s = 0; s < N_SLOTS; s++)
      for (int o = 0; o < N_OUT; o++) begin
        m_en[s][o] = 0;
        m_sel[s][o] = 0;
      end
    for (int i = 0; i < N_IN; i++) begin
      p_val[i] = 0; p_dat[i] = '0; drv_val[i] = 0; drv_dat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();          // R1
    t_load_random();    // R7
    t_stream();         // R2 R3 R4 R9
    t_gaps();           // R5
    t_idle_entry();     // R6
    t_midslot_write();  // R7
    t_oob_write();      // R8
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule